// File: doc/BRIEF.md
# Station-Address Loader with Image Checksum

This block runs once whenever it is started, normally just after the chip leaves reset. It reads the configuration image of an attached serial EEPROM through a simple request/response read port. The serial wire protocol is handled by a separate engine behind that port. The loader first works out how many address bits the attached part expects. It then reads the 64-word image from the start, keeps a running 16-bit sum of every word, and collects the 48-bit station (MAC) address from the first three words.

When the last word has been summed, the loader compares the total with a fixed signature. If the two match, the assembled address is presented and flagged valid. If they differ, the address output is held at zero and an error flag is raised instead. A one-cycle done pulse tells the rest of the chip that the result is final.

Top module: `srom_addr_loader`

## Requirements
- R1: After reset, `mac_o` is zero, `mac_valid_o`, `cksum_err_o` and `done_o` are low, and `rd_req_o` is low.
- R2: A start accepted while idle clears `mac_o`, `mac_valid_o` and `cksum_err_o` to zero in the next cycle. The first read it issues is a probe of word 0 with `rd_alen_o` = 6.
- R3: If the probe returns 0xFFFF, every later read of the load uses `rd_alen_o` = 8. Otherwise every later read uses 6.
- R4: After the probe, exactly 64 reads are issued, at addresses 0, 1, ... 63 in ascending order. Each read advances only when its response is taken. The probe word is not part of the sum.
- R5: The 64 words are summed modulo 2^16. `mac_valid_o` goes high if the sum equals 0xBABA, and `cksum_err_o` goes high otherwise. The two flags are never high together.
- R6: On a passing image, `mac_o[47:40]` is word 0 bits 7:0, `mac_o[39:32]` is word 0 bits 15:8, `mac_o[31:24]` is word 1 bits 7:0, `mac_o[23:16]` is word 1 bits 15:8, `mac_o[15:8]` is word 2 bits 7:0, and `mac_o[7:0]` is word 2 bits 15:8.
- R7: On a failing image, `mac_o` is all zeros while `cksum_err_o` is high.
- R8: `done_o` is high for exactly one cycle: the second cycle after the clock edge that takes the last response. The new `mac_o` and flags appear in that same cycle and hold until the next accepted start.
- R9: `start_i` is ignored while a load is in progress. The read sequence and the result are unchanged.
- R10: `rd_req_o` stays high with `rd_addr_o` and `rd_alen_o` unchanged until `rd_done_i` is seen. `rd_data_i` is taken only in a cycle where both `rd_req_o` and `rd_done_i` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a load (single-cycle pulse) |
| rd_req_o | output | 1 | Read request to the EEPROM engine |
| rd_addr_o | output | 8 | Word address of the read |
| rd_alen_o | output | 4 | Address length in bits for this read (6 or 8) |
| rd_data_i | input | 16 | Word returned by the engine |
| rd_done_i | input | 1 | Response strobe; `rd_data_i` is valid with it |
| mac_o | output | 48 | Station address, first byte in the top bits |
| mac_valid_o | output | 1 | Image checksum matched |
| cksum_err_o | output | 1 | Image checksum mismatched; address zeroed |
| done_o | output | 1 | One-cycle pulse when the result is final |

## Verification
The bench uses the default parameters throughout: 16-bit words, a 64-word image, 6/8-bit address lengths and three address words. With these values, a full load fits in a few hundred cycles, so the bench can run many complete loads. Its EEPROM model can behave as either a short-address or a long-address part, and a mismatched address length returns all ones. A wrong width choice therefore shows up directly as a checksum failure. Response latency varies from zero to three cycles, which exercises the request hold rule. Images are built so that the running sum wraps many times before landing on or just off the signature.

// File: rtl/srom_ldr_pkg.sv
// Package: shared types for the station-address loader.
// Assumes: nothing beyond IEEE 1800-2017.
package srom_ldr_pkg;
    typedef enum logic [1:0] {
        LD_IDLE  = 2'd0,
        LD_PROBE = 2'd1,
        LD_FETCH = 2'd2,
        LD_JUDGE = 2'd3
    } ldr_state_e;
endpackage

// File: rtl/srom_load_seq.sv
// Module: srom_load_seq
// Drives the EEPROM read port. It probes word 0 with the short address
// length, picks the address length for the rest of the load, then walks
// word addresses 0..NUM_WORDS-1 and spends one judge cycle at the end.
// Assumes: the responder holds rd_done_i for one cycle per response and
// accepts a request that stays high across consecutive reads.
module srom_load_seq
    import srom_ldr_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int NUM_WORDS = 64,
    parameter int SHORT_AW  = 6,
    parameter int LONG_AW   = 8,
    parameter int AL_W      = 4,
    parameter int IDX_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              rd_done_i,
    input  logic [WORD_W-1:0] rd_data_i,
    output logic              rd_req_o,
    output logic [LONG_AW-1:0] rd_addr_o,
    output logic [AL_W-1:0]   rd_alen_o,
    output logic              clear_o,
    output logic              take_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              judge_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);
    localparam logic [AL_W-1:0]  ALEN_S   = AL_W'(SHORT_AW);
    localparam logic [AL_W-1:0]  ALEN_L   = AL_W'(LONG_AW);

    ldr_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             wide_q;
    logic             hit;

    assign hit = rd_req_o && rd_done_i;

    // Next-state decode for the load sequence.
    always_comb begin
        state_d = state_q;
        case (state_q)
            LD_IDLE:  if (start_i) state_d = LD_PROBE;
            LD_PROBE: if (hit) state_d = LD_FETCH;
            LD_FETCH: if (hit && idx_q == LAST_IDX) state_d = LD_JUDGE;
            LD_JUDGE: state_d = LD_IDLE;
            default:  state_d = LD_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LD_IDLE;
        else        state_q <= state_d;
    end

    // Word index and address-length choice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            wide_q <= 1'b0;
        end else if (state_q == LD_PROBE && hit) begin
            idx_q  <= '0;
            wide_q <= (rd_data_i == {WORD_W{1'b1}});
        end else if (state_q == LD_FETCH && hit && idx_q != LAST_IDX) begin
            idx_q  <= idx_q + 1'b1;
        end
    end

    // Read-port and datapath control outputs.
    always_comb begin
        rd_req_o  = (state_q == LD_PROBE) || (state_q == LD_FETCH);
        rd_addr_o = (state_q == LD_FETCH) ? LONG_AW'(idx_q) : '0;
        rd_alen_o = (state_q == LD_FETCH && wide_q) ? ALEN_L : ALEN_S;
        clear_o   = (state_q == LD_IDLE) && start_i;
        take_o    = (state_q == LD_FETCH) && hit;
        idx_o     = idx_q;
        judge_o   = (state_q == LD_JUDGE);
    end

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_done_i) |=> (rd_req_o && $stable(rd_addr_o) && $stable(rd_alen_o)));

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && idx_q != LAST_IDX) |=> (rd_addr_o == LONG_AW'($past(rd_addr_o) + 1'b1)));

    // R3
    wide_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LD_PROBE && hit && rd_data_i == {WORD_W{1'b1}}) |=> (rd_alen_o == ALEN_L));

    // R8
    judge_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        judge_o |=> !judge_o);
endmodule

// File: rtl/srom_sum_acc.sv
// Module: srom_sum_acc
// Running image sum. It wraps modulo 2^WORD_W and is cleared when a load starts.
// Assumes: clear_i and add_i are never high together.
module srom_sum_acc #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              add_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] sum_o
);
    // Accumulate each taken word; the carry out is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) sum_o <= '0;
        else if (add_i)        sum_o <= sum_o + word_i;
    end
endmodule

// File: rtl/srom_mac_assemble.sv
// Module: srom_mac_assemble
// Captures the leading ADDR_WORDS words of the image and lays out their
// bytes low-byte-first, with the first byte in the top bits of mac_o.
// Assumes: WORD_W is a multiple of 8.
module srom_mac_assemble #(
    parameter int WORD_W     = 16,
    parameter int ADDR_WORDS = 3,
    parameter int IDX_W      = 6,
    parameter int MAC_W      = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              take_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [MAC_W-1:0]  mac_o
);
    localparam int BPW = WORD_W / 8;

    logic [WORD_W-1:0] word_q [ADDR_WORDS];

    for (genvar g = 0; g < ADDR_WORDS; g++) begin : g_word
        // Latch address word g when its index comes by.
        always_ff @(posedge clk) begin
            if (!rst_n || clear_i)
                word_q[g] <= '0;
            else if (take_i && idx_i == IDX_W'(g))
                word_q[g] <= word_i;
        end
        for (genvar b = 0; b < BPW; b++) begin : g_byte
            assign mac_o[MAC_W-1-8*(g*BPW+b) -: 8] = word_q[g][8*b +: 8];
        end
    end
endmodule

// File: rtl/srom_addr_loader.sv
// Module: srom_addr_loader (top)
// Loads the station address from an EEPROM image and checks the image sum.
// The sequencer drives the read port, the accumulator sums the words, and
// the assembler collects the address. Results are registered here at the
// judge cycle.
// Assumes: the read engine behind rd_* handles the serial protocol.
module srom_addr_loader
    import srom_ldr_pkg::*;
#(
    parameter int                WORD_W     = 16,
    parameter int                NUM_WORDS  = 64,
    parameter int                SHORT_AW   = 6,
    parameter int                LONG_AW    = 8,
    parameter int                ADDR_WORDS = 3,
    parameter logic [WORD_W-1:0] SUM_SIG    = 16'hBABA,
    localparam int               AL_W       = $clog2(LONG_AW + 1),
    localparam int               MAC_W      = ADDR_WORDS * WORD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    output logic               rd_req_o,
    output logic [LONG_AW-1:0] rd_addr_o,
    output logic [AL_W-1:0]    rd_alen_o,
    input  logic [WORD_W-1:0]  rd_data_i,
    input  logic               rd_done_i,
    output logic [MAC_W-1:0]   mac_o,
    output logic               mac_valid_o,
    output logic               cksum_err_o,
    output logic               done_o
);
    localparam int IDX_W = $clog2(NUM_WORDS);

    logic              clear_w, take_w, judge_w;
    logic [IDX_W-1:0]  idx_w;
    logic [WORD_W-1:0] sum_w;
    logic [MAC_W-1:0]  raw_mac_w;
    logic              pass_w;

    srom_load_seq #(
        .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .SHORT_AW(SHORT_AW),
        .LONG_AW(LONG_AW), .AL_W(AL_W), .IDX_W(IDX_W)
    ) seq_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .rd_done_i(rd_done_i), .rd_data_i(rd_data_i),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_alen_o(rd_alen_o),
        .clear_o(clear_w), .take_o(take_w), .idx_o(idx_w), .judge_o(judge_w)
    );

    srom_sum_acc #(.WORD_W(WORD_W)) acc_i (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_w), .add_i(take_w),
        .word_i(rd_data_i), .sum_o(sum_w)
    );

    srom_mac_assemble #(
        .WORD_W(WORD_W), .ADDR_WORDS(ADDR_WORDS), .IDX_W(IDX_W), .MAC_W(MAC_W)
    ) asm_i (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_w), .take_i(take_w),
        .idx_i(idx_w), .word_i(rd_data_i), .mac_o(raw_mac_w)
    );

    assign pass_w = (sum_w == SUM_SIG);

    // Result registers: cleared on start, set at the judge cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_w) begin
            mac_o       <= '0;
            mac_valid_o <= 1'b0;
            cksum_err_o <= 1'b0;
            done_o      <= 1'b0;
        end else if (judge_w) begin
            mac_o       <= pass_w ? raw_mac_w : '0;
            mac_valid_o <= pass_w;
            cksum_err_o <= !pass_w;
            done_o      <= 1'b1;
        end else begin
            done_o      <= 1'b0;
        end
    end

    // R7
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cksum_err_o |-> (mac_o == '0));

    // R5
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mac_valid_o && cksum_err_o));

    // R5
    verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (mac_valid_o == (sum_w == SUM_SIG)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    done_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(take_w, 2));
endmodule

// File: tb/srom_addr_loader_tb.sv
// Bench: srom_addr_loader_tb_top
// Behavioural EEPROM responder plus an event-driven reference model.
// Outputs are compared on every falling edge.
module srom_addr_loader_tb_top;
    localparam int WORD_W = 16;
    localparam int MAC_W  = 48;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              rd_req_o;
    logic [7:0]        rd_addr_o;
    logic [3:0]        rd_alen_o;
    logic [WORD_W-1:0] rd_data_i = '0;
    logic              rd_done_i = 1'b0;
    logic [MAC_W-1:0]  mac_o;
    logic              mac_valid_o, cksum_err_o, done_o;

    srom_addr_loader dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_alen_o(rd_alen_o),
        .rd_data_i(rd_data_i), .rd_done_i(rd_done_i),
        .mac_o(mac_o), .mac_valid_o(mac_valid_o),
        .cksum_err_o(cksum_err_o), .done_o(done_o)
    );

    int checks = 0;
    int errors = 0;

    logic [15:0] img [64];
    bit          wide_part = 0;
    int          lat = 0;
    bit          start_pending = 0;
    bit          busy_m = 0;
    int          countdown = 0;
    int          resp_cnt = 0;
    int          wait_cnt = 0;
    bit          done_drv = 0;
    logic [7:0]  held_addr = '0;
    logic [3:0]  held_alen = '0;
    logic [15:0] probe_val = '0;
    logic [15:0] sum_m = '0;
    logic [15:0] ret_w [3];
    logic [47:0] exp_mac = '0;
    bit          exp_valid = 0, exp_err = 0, exp_done = 0;
    int          fin_cnt = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [15:0] eeprom_word(input logic [7:0] a, input logic [3:0] al);
        if (al == 4'd6 && wide_part)  return 16'hFFFF;
        if (al == 4'd8 && !wide_part) return 16'hFFFF;
        return img[a[5:0]];
    endfunction

    // Per-clock compare, model update, start driver and EEPROM responder.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(mac_o == exp_mac, "R6 mac per-clock", 64'(mac_o), 64'(exp_mac));
            chk(mac_valid_o == exp_valid, "R5 valid per-clock", 64'(mac_valid_o), 64'(exp_valid));
            chk(cksum_err_o == exp_err, "R7 err per-clock", 64'(cksum_err_o), 64'(exp_err));
            chk(done_o == exp_done, "R8 done per-clock", 64'(done_o), 64'(exp_done));
            if (!busy_m) chk(rd_req_o == 1'b0, "R10 idle request", 64'(rd_req_o), 64'd0);

            if (exp_done) busy_m = 0;
            exp_done = 0;
            if (countdown > 0) begin
                countdown--;
                if (countdown == 0) begin
                    exp_done = 1;
                    fin_cnt++;
                    if (sum_m == 16'hBABA) begin
                        exp_valid = 1;
                        exp_mac = {ret_w[0][7:0], ret_w[0][15:8], ret_w[1][7:0],
                                   ret_w[1][15:8], ret_w[2][7:0], ret_w[2][15:8]};
                    end else begin
                        exp_err = 1;
                        exp_mac = '0;
                    end
                end
            end

            if (start_i) start_i = 1'b0;
            else if (start_pending) begin
                start_pending = 0;
                start_i = 1'b1;
                if (!busy_m) begin
                    busy_m = 1; exp_mac = '0; exp_valid = 0; exp_err = 0;
                    resp_cnt = 0; sum_m = '0; wait_cnt = 0;
                end
            end

            if (done_drv) begin
                done_drv = 0; rd_done_i = 1'b0; wait_cnt = 0;
            end else if (rd_req_o) begin
                if (wait_cnt > 0)
                    chk(rd_addr_o == held_addr && rd_alen_o == held_alen, "R10 hold",
                        64'({rd_alen_o, rd_addr_o}), 64'({held_alen, held_addr}));
                else begin
                    held_addr = rd_addr_o; held_alen = rd_alen_o;
                end
                if (wait_cnt >= lat) begin
                    logic [15:0] d;
                    d = eeprom_word(rd_addr_o, rd_alen_o);
                    if (resp_cnt == 0) begin
                        chk(rd_addr_o == 8'd0, "R2 probe address", 64'(rd_addr_o), 64'd0);
                        chk(rd_alen_o == 4'd6, "R2 probe length", 64'(rd_alen_o), 64'd6);
                        probe_val = d;
                    end else begin
                        chk(rd_addr_o == 8'(resp_cnt - 1), "R4 address order",
                            64'(rd_addr_o), 64'(resp_cnt - 1));
                        chk(rd_alen_o == ((probe_val == 16'hFFFF) ? 4'd8 : 4'd6), "R3 length",
                            64'(rd_alen_o), (probe_val == 16'hFFFF) ? 64'd8 : 64'd6);
                        sum_m = sum_m + d;
                        if (resp_cnt <= 3) ret_w[resp_cnt-1] = d;
                    end
                    rd_data_i = d; rd_done_i = 1'b1; done_drv = 1;
                    resp_cnt++;
                    if (resp_cnt == 65) countdown = 1;
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    // One load. mode 0: good image, 1: bad sum, 2: short part whose word 0 is all ones.
    task automatic run_load(input bit wide, input int latency, input int mode,
                            input bit mid_start, input int seed);
        logic [15:0] s;
        logic [47:0] want_mac;
        int target;
        @(posedge clk); #1;
        s = '0;
        for (int i = 0; i < 63; i++) begin
            img[i] = 16'((i * 16'h3A5B) ^ (seed * 16'h1F0D)) + 16'h0707 + 16'(i * seed);
            s = s + img[i];
        end
        img[63] = 16'hBABA - s + ((mode == 1) ? 16'd1 : 16'd0);
        if (mode == 2) img[0] = 16'hFFFF;
        wide_part = wide; lat = latency;
        target = fin_cnt + 1;
        start_pending = 1;
        wait (start_i == 1'b1);
        @(negedge clk);
        chk(mac_o == '0 && !mac_valid_o && !cksum_err_o, "R2 clear on start",
            64'({mac_valid_o, cksum_err_o, mac_o}), 64'd0);
        chk(rd_req_o == 1'b1, "R2 request after start", 64'(rd_req_o), 64'd1);
        if (mid_start) begin
            repeat (30) @(posedge clk);
            #1 start_pending = 1;
            repeat (25) @(posedge clk);
            #1 start_pending = 1;
        end
        wait (fin_cnt == target);
        @(negedge clk);
        chk(done_o == 1'b1, "R8 done at result", 64'(done_o), 64'd1);
        chk(resp_cnt == 65, "R4 read count (R9 no restart)", 64'(resp_cnt), 64'd65);
        want_mac = {img[0][7:0], img[0][15:8], img[1][7:0], img[1][15:8], img[2][7:0], img[2][15:8]};
        if (mode == 0) begin
            chk(mac_valid_o && !cksum_err_o, "R5 pass flags", 64'({mac_valid_o, cksum_err_o}), 64'b10);
            chk(mac_o == want_mac, "R6 byte order", 64'(mac_o), 64'(want_mac));
        end else begin
            chk(!mac_valid_o && cksum_err_o, "R5 fail flags", 64'({mac_valid_o, cksum_err_o}), 64'b01);
            chk(mac_o == '0, "R7 zeroed address", 64'(mac_o), 64'd0);
        end
        @(negedge clk);
        chk(done_o == 1'b0, "R8 single-cycle done", 64'(done_o), 64'd0);
        repeat (3) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(mac_o == '0 && !mac_valid_o && !cksum_err_o && !done_o, "R1 reset outputs",
            64'({done_o, mac_valid_o, cksum_err_o, mac_o}), 64'd0);
        chk(rd_req_o == 1'b0, "R1 reset request", 64'(rd_req_o), 64'd0);
        run_load(1'b0, 1, 0, 1'b0, 3);
        run_load(1'b1, 2, 0, 1'b1, 7);
        run_load(1'b0, 0, 1, 1'b0, 11);
        run_load(1'b0, 3, 2, 1'b0, 5);
        run_load(1'b1, 0, 0, 1'b0, 9);
        run_load(1'b1, 1, 1, 1'b1, 13);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog expired: done count actual=%0d expected=6", fin_cnt);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule